// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit forms the data and branch-target addresses for a small 32-bit processor core. For each request it takes an already decoded mode code, two register selectors (base and index), a 32-bit immediate field, a scale code, an access-size code and the program counter of the current instruction. It reads an internal file of eight 32-bit registers and returns the effective address, with a valid strobe, one clock later. In the post-increment and pre-decrement modes it also writes the adjusted base register back, on the same edge that presents the result.

Register 0 is wired to zero, so pointing a base-plus-displacement request at it gives a plain absolute address. A preload port fills the register file before use. All address arithmetic wraps modulo 2^32. Instructions are taken to be four bytes long, so the next instruction sits at `pc + 4`.

A two-state controller sequences the result. In state `ST_IDLE` the strobe is low. The transition `IDLE_TO_ISSUE` happens on a request that carries a defined mode. In state `ST_ISSUE` the strobe is high. The transition `ISSUE_TO_ISSUE` happens on a back-to-back defined request, and `ISSUE_TO_IDLE` happens when there is no request or the mode is undefined. An undefined mode seen while idle takes `IDLE_HOLD`.

Top module: `addr_gen_unit`

## Requirements
- R1: A request with a defined mode (codes 0 to 11) raises `ea_valid` at the first rising edge after `req` is sampled, with `ea` valid in the same cycle. `ea_valid` stays high for as many cycles as there are consecutive requests and is low otherwise. After reset, `ea_valid` is 0 and `ea` is 0.
- R2: Mode 0 (absolute) gives `ea = field`, all 32 bits unchanged.
- R3: Mode 1 (PC-relative) gives `ea = pc + 4 + field`, with `field` taken as a signed 32-bit offset.
- R4: Mode 2 (register indirect) gives `ea = reg[base_sel]`. Mode 3 (base plus displacement) gives `ea = reg[base_sel] + sign-extended field[15:0]`; `field[31:16]` is ignored.
- R5: Register 0 always reads as 0. Writes to it from the preload port or from write-back are discarded, so mode 3 with base 0 yields the sign-extended displacement alone.
- R6: Mode 4 (indexed absolute) gives `field + reg[index_sel]`. Mode 5 gives `reg[base_sel] + reg[index_sel]`. Mode 6 gives `reg[base_sel] + reg[index_sel] + sign-extended field[15:0]`.
- R7: Mode 7 (scaled index) gives `reg[base_sel] + (reg[index_sel] << scale)`, where scale code 0, 1, 2, 3 multiplies by 1, 2, 4, 8.
- R8: Mode 8 (post-increment) gives `ea = old reg[base_sel]` and writes `reg[base_sel] + 2^size` back on the same edge. The size code is encoded like the scale code: 1, 2, 4 or 8 bytes.
- R9: Mode 9 (pre-decrement) writes `reg[base_sel] - 2^size` back and returns that new value as `ea`.
- R10: Mode 10 (skip) gives `pc + 8`, the next instruction plus one. Mode 11 (sequential) gives `pc + 4`.
- R11: A request with an undefined mode (codes 12 to 15) leaves `ea_valid` low, leaves `ea` at its previous value and changes no register.
- R12: All sums and differences wrap modulo 2^32.
- R13: A preload write (`ld_en`) is visible to requests from the next cycle on. If a write-back and a preload target the same register on the same edge, the write-back value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request strobe, one address per cycle |
| mode | input | 4 | Address mode code (0 to 11 defined) |
| base_sel | input | 3 | Base register selector |
| index_sel | input | 3 | Index register selector |
| field | input | 32 | Immediate address, offset or displacement |
| scale | input | 2 | Index scale code (shift amount) |
| size | input | 2 | Access size code for post-increment and pre-decrement |
| pc | input | 32 | Address of the current instruction |
| ld_en | input | 1 | Preload write enable |
| ld_sel | input | 3 | Preload register selector |
| ld_data | input | 32 | Preload data |
| ea_valid | output | 1 | Effective address valid strobe |
| ea | output | 32 | Effective address |

## Verification
Every address result is due exactly one rising edge after the request is sampled. The bench drives `req` on a falling edge and reads `ea` and `ea_valid` on the next falling edge, then checks one cycle later that the strobe has dropped. Base write-back lands on that same edge, so the updated register is read through a register-indirect request issued in the next cycle. The preload-versus-write-back collision and back-to-back post-increments are driven in consecutive cycles, so the second address shows the value written back by the first.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;

    typedef enum logic [3:0] {
        EA_ABS     = 4'd0,
        EA_PCREL   = 4'd1,
        EA_REGIND  = 4'd2,
        EA_BASEOFF = 4'd3,
        EA_IDXABS  = 4'd4,
        EA_BASEIDX = 4'd5,
        EA_BIDXOFF = 4'd6,
        EA_SCALED  = 4'd7,
        EA_POSTINC = 4'd8,
        EA_PREDEC  = 4'd9,
        EA_SKIP    = 4'd10,
        EA_NEXT    = 4'd11
    } ea_mode_e;

    localparam logic [3:0] EA_LAST_MODE = 4'd11;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } ea_state_e;

endpackage

// File: rtl/addr_gen_regfile.sv
module addr_gen_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 8,
    localparam int SELW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] rd_sel_a,
    output logic [XLEN-1:0] rd_a,
    input  logic [SELW-1:0] rd_sel_b,
    output logic [XLEN-1:0] rd_b,
    input  logic            ld_en,
    input  logic [SELW-1:0] ld_sel,
    input  logic [XLEN-1:0] ld_data,
    input  logic            wb_en,
    input  logic [SELW-1:0] wb_sel,
    input  logic [XLEN-1:0] wb_data
);

    logic [XLEN-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        if (g == 0) begin : g_zero
            assign regs[g] = '0;
        end else begin : g_store
            logic hit_wb;
            logic hit_ld;
            assign hit_wb = wb_en && (wb_sel == SELW'(g));
            assign hit_ld = ld_en && (ld_sel == SELW'(g));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs[g] <= '0;
                end else if (hit_wb) begin
                    regs[g] <= wb_data;
                end else if (hit_ld) begin
                    regs[g] <= ld_data;
                end
            end
        end
    end

    assign rd_a = regs[rd_sel_a];
    assign rd_b = regs[rd_sel_b];

    // R5: a write aimed at register 0 never becomes visible
    p_r0_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ld_en && ld_sel == '0) || (wb_en && wb_sel == '0)) |=>
            (rd_sel_a != '0 || rd_a == '0));

endmodule

// File: rtl/addr_gen_compute.sv
module addr_gen_compute
    import addr_gen_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int OFFW = 16,
    parameter int INSN_BYTES = 4
) (
    input  logic [3:0]      mode,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] idx_val,
    input  logic [XLEN-1:0] field,
    input  logic [1:0]      scale,
    input  logic [1:0]      size,
    input  logic [XLEN-1:0] pc,
    output logic            legal,
    output logic [XLEN-1:0] ea_next,
    output logic            wb_req,
    output logic [XLEN-1:0] wb_val
);

    localparam logic [XLEN-1:0] NEXT_STEP = XLEN'(INSN_BYTES);
    localparam logic [XLEN-1:0] SKIP_STEP = XLEN'(2 * INSN_BYTES);

    ea_mode_e        m;
    logic [XLEN-1:0] disp;
    logic [XLEN-1:0] idx_scaled;
    logic [XLEN-1:0] step;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] base_up;
    logic [XLEN-1:0] base_dn;

    assign m          = ea_mode_e'(mode);
    assign disp       = {{(XLEN-OFFW){field[OFFW-1]}}, field[OFFW-1:0]};
    assign idx_scaled = idx_val << scale;
    assign step       = XLEN'(1) << size;
    assign pc_next    = pc + NEXT_STEP;
    assign base_up    = base_val + step;
    assign base_dn    = base_val - step;

    always_comb begin
        legal   = 1'b1;
        wb_req  = 1'b0;
        wb_val  = base_val;
        ea_next = '0;
        unique case (m)
            EA_ABS:     ea_next = field;
            EA_PCREL:   ea_next = pc_next + field;
            EA_REGIND:  ea_next = base_val;
            EA_BASEOFF: ea_next = base_val + disp;
            EA_IDXABS:  ea_next = field + idx_val;
            EA_BASEIDX: ea_next = base_val + idx_val;
            EA_BIDXOFF: ea_next = base_val + idx_val + disp;
            EA_SCALED:  ea_next = base_val + idx_scaled;
            EA_POSTINC: begin
                ea_next = base_val;
                wb_req  = 1'b1;
                wb_val  = base_up;
            end
            EA_PREDEC: begin
                ea_next = base_dn;
                wb_req  = 1'b1;
                wb_val  = base_dn;
            end
            EA_SKIP:    ea_next = pc + SKIP_STEP;
            EA_NEXT:    ea_next = pc_next;
            default:    legal   = 1'b0;
        endcase
    end

endmodule

// File: rtl/addr_gen_ctrl.sv
module addr_gen_ctrl
    import addr_gen_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            legal,
    input  logic [XLEN-1:0] ea_next,
    output logic            fire,
    output logic            ea_valid,
    output logic [XLEN-1:0] ea
);

    ea_state_e       state_q;
    ea_state_e       state_d;
    logic [XLEN-1:0] ea_q;

    assign fire = req && legal;

    // transitions: IDLE_TO_ISSUE, IDLE_HOLD, ISSUE_TO_ISSUE, ISSUE_TO_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = fire ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = fire ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q <= '0;
        end else if (fire) begin
            ea_q <= ea_next;
        end
    end

    assign ea_valid = (state_q == ST_ISSUE);
    assign ea       = ea_q;

    // R1: a defined request is answered on the next edge
    p_valid_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req && legal) |=> ea_valid);

    // R1: no strobe without a request in the previous cycle
    p_no_spurious_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !ea_valid);

    // R11: an undefined mode gives no strobe and holds the address
    p_undefined_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !legal) |=> (!ea_valid && $stable(ea)));

endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
    import addr_gen_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int NREG       = 8,
    parameter int OFFW       = 16,
    parameter int INSN_BYTES = 4,
    localparam int SELW      = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [3:0]      mode,
    input  logic [SELW-1:0] base_sel,
    input  logic [SELW-1:0] index_sel,
    input  logic [XLEN-1:0] field,
    input  logic [1:0]      scale,
    input  logic [1:0]      size,
    input  logic [XLEN-1:0] pc,
    input  logic            ld_en,
    input  logic [SELW-1:0] ld_sel,
    input  logic [XLEN-1:0] ld_data,
    output logic            ea_valid,
    output logic [XLEN-1:0] ea
);

    logic [XLEN-1:0] base_val;
    logic [XLEN-1:0] idx_val;
    logic            legal;
    logic [XLEN-1:0] ea_next;
    logic            wb_req;
    logic [XLEN-1:0] wb_val;
    logic            fire;

    addr_gen_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel_a (base_sel),
        .rd_a     (base_val),
        .rd_sel_b (index_sel),
        .rd_b     (idx_val),
        .ld_en    (ld_en),
        .ld_sel   (ld_sel),
        .ld_data  (ld_data),
        .wb_en    (fire && wb_req),
        .wb_sel   (base_sel),
        .wb_data  (wb_val)
    );

    addr_gen_compute #(.XLEN(XLEN), .OFFW(OFFW), .INSN_BYTES(INSN_BYTES)) u_calc (
        .mode     (mode),
        .base_val (base_val),
        .idx_val  (idx_val),
        .field    (field),
        .scale    (scale),
        .size     (size),
        .pc       (pc),
        .legal    (legal),
        .ea_next  (ea_next),
        .wb_req   (wb_req),
        .wb_val   (wb_val)
    );

    addr_gen_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .legal    (legal),
        .ea_next  (ea_next),
        .fire     (fire),
        .ea_valid (ea_valid),
        .ea       (ea)
    );

    // R2: absolute mode passes the field straight through
    p_abs_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 4'd0) |=> (ea == $past(field)));

    // R8: post-increment returns the base as read before the update
    p_postinc_old_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 4'd8) |=> (ea == $past(base_val)));

endmodule

// File: tb/tb_addr_gen_unit.sv
module tb_addr_gen_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [3:0]  mode = '0;
    logic [2:0]  base_sel = '0;
    logic [2:0]  index_sel = '0;
    logic [31:0] field = '0;
    logic [1:0]  scale = '0;
    logic [1:0]  size = '0;
    logic [31:0] pc = '0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_sel = '0;
    logic [31:0] ld_data = '0;
    logic        ea_valid;
    logic [31:0] ea;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    addr_gen_unit dut (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode),
        .base_sel(base_sel), .index_sel(index_sel), .field(field),
        .scale(scale), .size(size), .pc(pc), .ld_en(ld_en),
        .ld_sel(ld_sel), .ld_data(ld_data), .ea_valid(ea_valid), .ea(ea)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic preload(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_data = data;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // drive one request, return the strobe and address one edge later
    task automatic issue(input logic [3:0] m, input logic [2:0] b, input logic [2:0] i,
                         input logic [31:0] f, input logic [1:0] sc, input logic [1:0] sz,
                         input logic [31:0] p, output logic v, output logic [31:0] a);
        @(negedge clk);
        req = 1'b1; mode = m; base_sel = b; index_sel = i;
        field = f; scale = sc; size = sz; pc = p;
        @(negedge clk);
        v = ea_valid; a = ea;
        req = 1'b0;
    endtask

    task automatic expect_ea(input string tag, input logic [3:0] m, input logic [2:0] b,
                             input logic [2:0] i, input logic [31:0] f, input logic [1:0] sc,
                             input logic [1:0] sz, input logic [31:0] p, input logic [31:0] exp);
        logic v;
        logic [31:0] a;
        issue(m, b, i, f, sc, sz, p, v, a);
        check({tag, " strobe"}, {31'd0, v}, 32'd1);
        check(tag, a, exp);
    endtask

    task automatic read_reg(input string tag, input logic [2:0] sel, input logic [31:0] exp);
        expect_ea(tag, 4'd2, sel, 3'd0, 32'd0, 2'd0, 2'd0, 32'd0, exp);
    endtask

    task automatic t_reset;
        check("R1 reset strobe", {31'd0, ea_valid}, 32'd0);
        check("R1 reset address", ea, 32'd0);
    endtask

    task automatic t_strobe_drops;
        logic v;
        logic [31:0] a;
        issue(4'd0, 3'd0, 3'd0, 32'h0000_1111, 2'd0, 2'd0, 32'd0, v, a);
        check("R1 strobe one cycle", {31'd0, v}, 32'd1);
        @(negedge clk);
        check("R1 strobe low after", {31'd0, ea_valid}, 32'd0);
        check("R1 address held", ea, 32'h0000_1111);
    endtask

    task automatic t_absolute_and_pc;
        expect_ea("R2 absolute", 4'd0, 3'd1, 3'd2, 32'hDEAD_BEEF, 2'd0, 2'd0, 32'h100, 32'hDEAD_BEEF);
        expect_ea("R3 pc forward", 4'd1, 3'd0, 3'd0, 32'h0000_0020, 2'd0, 2'd0, 32'h100, 32'h0000_0124);
        expect_ea("R3 pc backward", 4'd1, 3'd0, 3'd0, 32'hFFFF_FFF8, 2'd0, 2'd0, 32'h100, 32'h0000_00FC);
    endtask

    task automatic t_register_based;
        read_reg("R4 indirect", 3'd1, 32'h0000_1000);
        expect_ea("R4 disp negative, upper ignored", 4'd3, 3'd1, 3'd0, 32'hABCD_FFFC, 2'd0, 2'd0, 32'd0, 32'h0000_0FFC);
        expect_ea("R4 disp positive", 4'd3, 3'd1, 3'd0, 32'h0000_7FFF, 2'd0, 2'd0, 32'd0, 32'h0000_8FFF);
        expect_ea("R5 base r0 absolute", 4'd3, 3'd0, 3'd0, 32'h0000_1234, 2'd0, 2'd0, 32'd0, 32'h0000_1234);
    endtask

    task automatic t_indexed;
        expect_ea("R6 indexed absolute", 4'd4, 3'd0, 3'd2, 32'h0000_2000, 2'd0, 2'd0, 32'd0, 32'h0000_2010);
        expect_ea("R6 base plus index", 4'd5, 3'd1, 3'd2, 32'd0, 2'd0, 2'd0, 32'd0, 32'h0000_1010);
        expect_ea("R6 base index disp", 4'd6, 3'd1, 3'd2, 32'h0000_FFFF, 2'd0, 2'd0, 32'd0, 32'h0000_100F);
        expect_ea("R7 scale x1", 4'd7, 3'd1, 3'd2, 32'd0, 2'd0, 2'd0, 32'd0, 32'h0000_1010);
        expect_ea("R7 scale x4", 4'd7, 3'd1, 3'd2, 32'd0, 2'd2, 2'd0, 32'd0, 32'h0000_1040);
        expect_ea("R7 scale x8", 4'd7, 3'd1, 3'd2, 32'd0, 2'd3, 2'd0, 32'd0, 32'h0000_1080);
    endtask

    task automatic t_wrap;
        expect_ea("R12 sum wraps", 4'd5, 3'd3, 3'd2, 32'd0, 2'd0, 2'd0, 32'd0, 32'h0000_0000);
        expect_ea("R12 pc wraps", 4'd1, 3'd0, 3'd0, 32'd0, 2'd0, 2'd0, 32'hFFFF_FFFC, 32'h0000_0000);
    endtask

    task automatic t_auto_modes;
        expect_ea("R8 postinc old base", 4'd8, 3'd1, 3'd0, 32'd0, 2'd0, 2'd2, 32'd0, 32'h0000_1000);
        read_reg("R8 base plus 4", 3'd1, 32'h0000_1004);
        expect_ea("R8 postinc size 8", 4'd8, 3'd1, 3'd0, 32'd0, 2'd0, 2'd3, 32'd0, 32'h0000_1004);
        read_reg("R8 base plus 8", 3'd1, 32'h0000_100C);
        expect_ea("R9 predec new base", 4'd9, 3'd2, 3'd0, 32'd0, 2'd0, 2'd0, 32'd0, 32'h0000_000F);
        read_reg("R9 base minus 1", 3'd2, 32'h0000_000F);
        expect_ea("R9 predec wraps R12", 4'd9, 3'd6, 3'd0, 32'd0, 2'd0, 2'd1, 32'd0, 32'hFFFF_FFFE);
        expect_ea("R5 postinc on r0", 4'd8, 3'd0, 3'd0, 32'd0, 2'd0, 2'd3, 32'd0, 32'h0000_0000);
        read_reg("R5 r0 after writeback", 3'd0, 32'h0000_0000);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        req = 1'b1; mode = 4'd8; base_sel = 3'd5; size = 2'd1;
        @(negedge clk);
        check("R1 back-to-back first strobe", {31'd0, ea_valid}, 32'd1);
        check("R8 back-to-back first", ea, 32'h0000_0500);
        @(negedge clk);
        check("R1 back-to-back second strobe", {31'd0, ea_valid}, 32'd1);
        check("R8 back-to-back second", ea, 32'h0000_0502);
        req = 1'b0;
        read_reg("R8 back-to-back final", 3'd5, 32'h0000_0504);
    endtask

    task automatic t_sequencing;
        expect_ea("R10 skip", 4'd10, 3'd0, 3'd0, 32'd0, 2'd0, 2'd0, 32'h200, 32'h0000_0208);
        expect_ea("R10 sequential", 4'd11, 3'd0, 3'd0, 32'd0, 2'd0, 2'd0, 32'h200, 32'h0000_0204);
    endtask

    task automatic t_undefined;
        logic v;
        logic [31:0] a;
        for (int k = 12; k < 16; k++) begin
            issue(4'(k), 3'd7, 3'd0, 32'h0000_9999, 2'd0, 2'd3, 32'd0, v, a);
            check("R11 no strobe", {31'd0, v}, 32'd0);
            check("R11 address held", a, 32'h0000_0204);
        end
        read_reg("R11 register untouched", 3'd7, 32'h8000_0000);
    endtask

    task automatic t_preload;
        preload(3'd0, 32'h0000_0055);
        read_reg("R5 r0 preload dropped", 3'd0, 32'h0000_0000);
        preload(3'd4, 32'h0000_0040);
        read_reg("R13 preload visible", 3'd4, 32'h0000_0040);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 3'd4; ld_data = 32'h0000_0999;
        req = 1'b1; mode = 4'd8; base_sel = 3'd4; size = 2'd0;
        @(negedge clk);
        ld_en = 1'b0; req = 1'b0;
        check("R13 collision address", ea, 32'h0000_0040);
        read_reg("R13 writeback wins", 3'd4, 32'h0000_0041);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        preload(3'd1, 32'h0000_1000);
        preload(3'd2, 32'h0000_0010);
        preload(3'd3, 32'hFFFF_FFF0);
        preload(3'd5, 32'h0000_0500);
        preload(3'd6, 32'h0000_0000);
        preload(3'd7, 32'h8000_0000);
        t_strobe_drops();
        t_absolute_and_pc();
        t_register_based();
        t_indexed();
        t_wrap();
        t_auto_modes();
        t_back_to_back();
        t_sequencing();
        t_undefined();
        t_preload();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule